// File: doc/BRIEF.md
# I2C Transmit Acknowledge Judgement and Flag Control

This block sits next to an I2C byte shifter. When the shifter reports that a transmitted byte has finished, the block decides which status flags to raise. The inputs to that decision are the acknowledge bit returned by the receiver and an enable bit for acknowledge judgement. The flags are transmit-data-empty, interrupt and transfer-request. The block also keeps an acknowledge status bit. The shifter, the bus timing and arbitration are outside the block and appear only as a byte-complete strobe and the sampled acknowledge value.

The transfer-request flag drives a small built-in model of a DMA-style engine. Software arms the engine with a transfer count. While the engine is running and the request flag is set, it performs one transfer per request. Each transfer empties the data-empty and request flags. The last transfer clears all three flags and ends the run. The CPU interrupt is masked for the whole run, so a clean run of continuous transfers raises no interrupt.

A negative acknowledge with judgement enabled raises only the interrupt flag. No request is made, so the continuous run stops at once and software handles the error through the interrupt.

Top module: `i2c_ack_flag_ctrl`

## Requirements
- R1: With `judge_en` low, `ack_stat` reads 0 one cycle later and stays 0 whatever `rx_ack` does.
- R2: With `judge_en` low, a `byte_done` pulse sets `tde_flag`, `irq_flag` and `trq_flag` at the next edge for either value of `rx_ack`.
- R3: With `judge_en` high and `rx_ack` 0 (acknowledge), a `byte_done` pulse sets all three flags at the next edge.
- R4: With `judge_en` high and `rx_ack` 1 (negative acknowledge), a `byte_done` pulse sets only `irq_flag`. `tde_flag` and `trq_flag` keep their prior value, and any active transfer run is aborted.
- R5: With `judge_en` high, `ack_stat` takes the `rx_ack` value sampled with `byte_done` and holds it until the next such strobe.
- R6: A `sw_wr` pulse clears every flag whose `sw_wdata` bit is 0 and leaves flags whose bit is 1 unchanged. Bit 0 is tde, bit 1 is irq and bit 2 is trq.
- R7: When a set condition and a clear of the same flag occur in the same cycle, the flag ends up set.
- R8: While `dma_busy` is high and `trq_flag` is set, `dma_xfer` is high for that cycle. At the following edge the transfer clears `tde_flag` and `trq_flag` and counts down the remaining transfers.
- R9: The transfer that uses up the programmed count clears all three flags and drops `dma_busy`.
- R10: `irq_out` equals `irq_flag` AND `irq_en`, and is held low while `dma_busy` is high.
- R11: A `dma_start` pulse loads `dma_len` and raises `dma_busy` at the next edge. A length of 0 leaves `dma_busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_done | input | 1 | Transmitted byte complete strobe |
| rx_ack | input | 1 | Acknowledge bit sampled from receiver (1 = NACK) |
| judge_en | input | 1 | Acknowledge judgement enable |
| irq_en | input | 1 | CPU interrupt enable |
| sw_wr | input | 1 | Software flag write strobe |
| sw_wdata | input | 3 | Flag write data: bit0 tde, bit1 irq, bit2 trq; 0 clears |
| dma_start | input | 1 | Arm a transfer run |
| dma_len | input | CNT_W | Number of transfers for the run |
| tde_flag | output | 1 | Transmit-data-empty flag |
| irq_flag | output | 1 | Interrupt flag |
| trq_flag | output | 1 | Transfer-request flag |
| ack_stat | output | 1 | Latched acknowledge status |
| irq_out | output | 1 | CPU interrupt request |
| dma_xfer | output | 1 | One transfer performed this cycle |
| dma_busy | output | 1 | Transfer run in progress |

## Verification
Every flag, `ack_stat` and `dma_busy` is a register. Each changes at the first rising edge that samples its stimulus. `irq_out` and `dma_xfer` are combinational from those registers, so they are valid in the same cycle as the flags that drive them. The bench drives inputs one time unit after an edge and reads results one time unit after the next edge. A transfer therefore appears as `dma_xfer` high in the cycle after the byte completes, and its clearing effect appears one edge later. Each check is placed at the exact cycle that this count predicts.

// File: rtl/ackflag_pkg.sv
package ackflag_pkg;
    typedef struct packed {
        logic trq;
        logic irq;
        logic tde;
    } flags_t;
endpackage

// File: rtl/ackflag_judge.sv
module ackflag_judge
    import ackflag_pkg::*;
(
    input  logic   byte_done,
    input  logic   rx_ack,
    input  logic   judge_en,
    output flags_t set_o,
    output logic   nack_o,
    output logic   ack_load_o,
    output logic   ack_clr_o
);
    logic good;

    always_comb begin
        good       = !judge_en || !rx_ack;
        set_o.tde  = byte_done && good;
        set_o.trq  = byte_done && good;
        set_o.irq  = byte_done;
        nack_o     = byte_done && judge_en && rx_ack;
        ack_load_o = byte_done && judge_en;
        ack_clr_o  = !judge_en;
    end
endmodule

// File: rtl/ackflag_regs.sv
module ackflag_regs
    import ackflag_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  flags_t set_i,
    input  flags_t sw_clr_i,
    input  flags_t dma_clr_i,
    input  logic   nack_i,
    input  logic   ack_load_i,
    input  logic   ack_val_i,
    input  logic   ack_clr_i,
    output flags_t flags_o,
    output logic   ack_o
);
    typedef struct packed {
        flags_t f;
        logic   ack;
    } regs_t;

    regs_t r_d, r_q;
    flags_t clr;

    always_comb begin
        r_d = r_q;
        clr = sw_clr_i | dma_clr_i;
        // set has priority over any clear
        r_d.f = set_i | (r_q.f & ~clr);
        if (ack_clr_i)       r_d.ack = 1'b0;
        else if (ack_load_i) r_d.ack = ack_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign flags_o = r_q.f;
    assign ack_o   = r_q.ack;

    assert_ack_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_clr_i |=> !r_q.ack);
    assert_nack_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_i && !r_q.f.trq) |=> !r_q.f.trq);
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i.irq && sw_clr_i.irq) |=> r_q.f.irq);
    assert_ack_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_load_i && !ack_clr_i) |=> (r_q.ack == $past(ack_val_i)));
endmodule

// File: rtl/ackflag_xfer.sv
module ackflag_xfer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             req_i,
    input  logic             abort_i,
    output logic             busy_o,
    output logic             xfer_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] left;
    } xs_t;

    xs_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        xfer_o = s_q.run && req_i;
        last_o = xfer_o && (s_q.left == ONE);
        if (start_i) begin
            s_d.left = len_i;
            s_d.run  = (len_i != '0);
        end else if (abort_i) begin
            s_d.run  = 1'b0;
            s_d.left = '0;
        end else if (xfer_o) begin
            s_d.left = s_q.left - ONE;
            if (last_o) s_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.run;

    assert_count_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (s_q.left != '0));
    assert_last_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !s_q.run);
    assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !start_i) |=> !s_q.run);
    assert_zero_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && len_i == '0) |=> !s_q.run);
endmodule

// File: rtl/i2c_ack_flag_ctrl.sv
module i2c_ack_flag_ctrl
    import ackflag_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_done,
    input  logic             rx_ack,
    input  logic             judge_en,
    input  logic             irq_en,
    input  logic             sw_wr,
    input  logic [2:0]       sw_wdata,
    input  logic             dma_start,
    input  logic [CNT_W-1:0] dma_len,
    output logic             tde_flag,
    output logic             irq_flag,
    output logic             trq_flag,
    output logic             ack_stat,
    output logic             irq_out,
    output logic             dma_xfer,
    output logic             dma_busy
);
    flags_t set_v, sw_clr, dma_clr, flags;
    logic   nack, ack_load, ack_clr, last;

    ackflag_judge u_judge (
        .byte_done (byte_done),
        .rx_ack    (rx_ack),
        .judge_en  (judge_en),
        .set_o     (set_v),
        .nack_o    (nack),
        .ack_load_o(ack_load),
        .ack_clr_o (ack_clr)
    );

    always_comb begin
        sw_clr     = sw_wr ? flags_t'(~sw_wdata) : '0;
        dma_clr.tde = dma_xfer;
        dma_clr.trq = dma_xfer;
        dma_clr.irq = last;
    end

    ackflag_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_v),
        .sw_clr_i  (sw_clr),
        .dma_clr_i (dma_clr),
        .nack_i    (nack),
        .ack_load_i(ack_load),
        .ack_val_i (rx_ack),
        .ack_clr_i (ack_clr),
        .flags_o   (flags),
        .ack_o     (ack_stat)
    );

    ackflag_xfer #(.CNT_W(CNT_W)) u_xfer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(dma_start),
        .len_i  (dma_len),
        .req_i  (flags.trq),
        .abort_i(nack),
        .busy_o (dma_busy),
        .xfer_o (dma_xfer),
        .last_o (last)
    );

    assign tde_flag = flags.tde;
    assign irq_flag = flags.irq;
    assign trq_flag = flags.trq;
    assign irq_out  = flags.irq && irq_en && !dma_busy;

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out |-> (irq_flag && irq_en && !dma_busy)));
    assert_last_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !byte_done) |=> (!tde_flag && !irq_flag && !trq_flag));
    assert_all_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !judge_en) |=> (tde_flag && irq_flag && trq_flag));
endmodule

// File: tb/i2c_ack_flag_ctrl_bench.sv
module i2c_ack_flag_ctrl_bench;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_done = 0, rx_ack = 0, judge_en = 0, irq_en = 0, sw_wr = 0, dma_start = 0;
    logic [2:0] sw_wdata = 3'b111;
    logic [CNT_W-1:0] dma_len = '0;
    logic tde_flag, irq_flag, trq_flag, ack_stat, irq_out, dma_xfer, dma_busy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    i2c_ack_flag_ctrl #(.CNT_W(CNT_W)) u_i2c_ack_flag_ctrl (.*);

    // {judge_en, rx_ack, exp tde, exp irq, exp trq, exp ack}
    localparam logic [5:0] VEC [4] = '{
        6'b00_1110, 6'b01_1110, 6'b10_1110, 6'b11_0101
    };

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        sw_wr = 1; sw_wdata = 3'b000; step(); sw_wr = 0; sw_wdata = 3'b111;
    endtask

    task automatic byte_end(logic a);
        rx_ack = a; byte_done = 1; step(); byte_done = 0; rx_ack = 0;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1; step();
        chk("reset flags", {5'd0, trq_flag, irq_flag, tde_flag}, 8'd0);
        chk("reset R11 busy", {7'd0, dma_busy}, 8'd0);

        foreach (VEC[i]) begin
            judge_en = VEC[i][5];
            clear_all();
            byte_end(VEC[i][4]);
            chk(VEC[i][5] ? (VEC[i][4] ? "R4 flags" : "R3 flags") : "R2 flags",
                {5'd0, trq_flag, irq_flag, tde_flag},
                {5'd0, VEC[i][1], VEC[i][2], VEC[i][3]});
            chk(VEC[i][5] ? "R5 ack" : "R1 ack", {7'd0, ack_stat}, {7'd0, VEC[i][0]});
        end

        // R1: disabling judgement clears a latched NACK
        judge_en = 0; step();
        chk("R1 ack cleared", {7'd0, ack_stat}, 8'd0);

        // R5: ACK after NACK latches 0; holds without strobe
        judge_en = 1; byte_end(1); byte_end(0);
        chk("R5 ack relatch", {7'd0, ack_stat}, 8'd0);
        rx_ack = 1; step(); rx_ack = 0;
        chk("R5 ack hold", {7'd0, ack_stat}, 8'd0);

        // R10: interrupt gating
        clear_all(); judge_en = 0; byte_end(0);
        chk("R10 irq masked", {7'd0, irq_out}, 8'd0);
        irq_en = 1; #1;
        chk("R10 irq enabled", {7'd0, irq_out}, 8'd1);

        // R6: write 1 no effect, write 0 clears selected
        sw_wr = 1; sw_wdata = 3'b111; step();
        chk("R6 write ones", {5'd0, trq_flag, irq_flag, tde_flag}, 8'd7);
        sw_wdata = 3'b101; step();
        chk("R6 clear irq", {5'd0, trq_flag, irq_flag, tde_flag}, 8'd5);
        sw_wdata = 3'b000; step();
        sw_wr = 0; sw_wdata = 3'b111;
        chk("R6 clear all", {5'd0, trq_flag, irq_flag, tde_flag}, 8'd0);

        // R7: set and clear in the same cycle
        sw_wr = 1; sw_wdata = 3'b000; byte_done = 1; step();
        sw_wr = 0; byte_done = 0; sw_wdata = 3'b111;
        chk("R7 set wins", {5'd0, trq_flag, irq_flag, tde_flag}, 8'd7);

        // R8/R9/R10: two-transfer run
        clear_all(); judge_en = 1;
        dma_start = 1; dma_len = 8'd2; step(); dma_start = 0;
        chk("R11 busy", {7'd0, dma_busy}, 8'd1);
        byte_end(0);
        chk("R8 xfer", {7'd0, dma_xfer}, 8'd1);
        chk("R10 masked in run", {7'd0, irq_out}, 8'd0);
        step();
        chk("R8 after xfer", {5'd0, trq_flag, irq_flag, tde_flag, dma_busy}, 8'b0100 >> 0 | 8'd1);
        chk("R8 no xfer idle", {7'd0, dma_xfer}, 8'd0);
        byte_end(0);
        chk("R8 xfer2", {7'd0, dma_xfer}, 8'd1);
        step();
        chk("R9 final clear", {4'd0, trq_flag, irq_flag, tde_flag, dma_busy}, 8'd0);
        chk("R9 no irq", {7'd0, irq_out}, 8'd0);

        // R4: NACK aborts a run and raises the interrupt
        clear_all();
        dma_start = 1; dma_len = 8'd3; step(); dma_start = 0;
        byte_end(1);
        chk("R4 abort", {4'd0, trq_flag, irq_flag, tde_flag, dma_busy}, 8'b0100);
        chk("R4 irq out", {7'd0, irq_out}, 8'd1);
        chk("R4 no xfer", {7'd0, dma_xfer}, 8'd0);

        // R11: zero length
        clear_all();
        dma_start = 1; dma_len = 8'd0; step(); dma_start = 0;
        chk("R11 zero len", {7'd0, dma_busy}, 8'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule